// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This block gathers the end-of-transfer events of up to eight DMA channels into one 32-bit status word. It keeps the inhibit masks that decide which of those events reach the single interrupt line. It also issues per-channel abort requests and reports whether the whole engine is idle. Each channel datapath lives outside the block. It shows up here only as three one-cycle event pulses (error, abort, terminal count) and a busy level.

Software reaches the unit through a small word-indexed register port. Reads are combinational and writes take effect at the clock edge. The status word has three banks of channel-indexed flags. Software clears a flag by writing a one to it. Abort requests are written as a channel bitmask. Each request is tracked by a three-state sequencer per channel: AB_IDLE, AB_PEND and AB_ACK. A write of one moves the sequencer from AB_IDLE or AB_ACK to AB_PEND. The channel's abort event moves it from AB_PEND to AB_ACK. AB_ACK returns to AB_IDLE on the next cycle unless a new request arrives in that cycle.

Top module: `dma_irq_unit`

## Requirements
- R1: An error pulse on channel c sets status bit c, an abort pulse sets bit 8+c, and a terminal-count pulse sets bit 16+c. Each bit is set at the clock edge that samples the pulse, and the status word is read at register index 0.
- R2: A write to index 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R3: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R4: The mask word at index 1 uses the status layout. A set mask bit keeps the matching status bit off the interrupt line. All implemented mask bits are 1 after reset.
- R5: irq is high exactly while some status bit is set and its mask bit is clear.
- R6: A write to index 2 raises abort_req for every channel written as 1 at that edge. Bits written as 0 have no effect. The pending requests read back at index 2.
- R7: A pending abort_req drops at the edge after the one that sets that channel's abort status flag.
- R8: The idle output and bit 0 of index 3 are 1 exactly when no ch_busy bit is set.
- R9: Bit 8+c of index 3 is 1 while channel c has none of its three status flags set, which marks the channel as ongoing.
- R10: After reset the status word, abort requests and irq are all 0.
- R11: Bits 24 to 31 of the status and mask words, and bits above the channel count everywhere, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 2 | Register index: 0 status, 1 mask, 2 abort, 3 idle/ongoing |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_err | input | NCH | Per-channel error event pulse |
| ev_abt | input | NCH | Per-channel abort event pulse |
| ev_tc | input | NCH | Per-channel terminal-count pulse |
| ch_busy | input | NCH | Per-channel busy level |
| abort_req | output | NCH | Per-channel abort request |
| irq | output | 1 | Combined interrupt line |
| idle | output | 1 | High when no channel is busy |

## Verification
The hardest case to reach is a clear and an event landing on the same status bit in one cycle, because the bench must line up a bus write with a channel pulse on the same edge. The driver raises the terminal-count pulse and the write-one-to-clear strobe in the same half-cycle, so that one edge samples both. The same write also clears a second bit that has no event, which shows that the clear itself worked. The abort sequencer's one-cycle AB_ACK window is checked on two consecutive cycles right after the abort pulse.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int DW          = 32;
    localparam int BANK_STRIDE = 8;
    localparam int NBANK       = 3;

    localparam logic [1:0] RG_STATUS = 2'd0;
    localparam logic [1:0] RG_MASK   = 2'd1;
    localparam logic [1:0] RG_ABORT  = 2'd2;
    localparam logic [1:0] RG_IDLE   = 2'd3;

    typedef enum logic [1:0] {
        AB_IDLE = 2'd0,
        AB_PEND = 2'd1,
        AB_ACK  = 2'd2
    } ab_state_e;

    function automatic logic [DW-1:0] impl_bits(input int nch);
        logic [DW-1:0] v;
        v = '0;
        for (int b = 0; b < NBANK; b++) begin
            for (int c = 0; c < nch; c++) begin
                v[b*BANK_STRIDE + c] = 1'b1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_err,
    input  logic [NCH-1:0] ev_abt,
    input  logic [NCH-1:0] ev_tc,
    input  logic [DW-1:0]  clr,
    output logic [DW-1:0]  stat
);

    logic [NBANK*NCH-1:0] ev_all;
    assign ev_all = {ev_tc, ev_abt, ev_err};

    always_comb begin
        stat = '0;
        for (int b = 0; b < NBANK; b++) begin
            for (int c = 0; c < NCH; c++) begin
                stat[b*BANK_STRIDE + c] = flag_q[b*NCH + c];
            end
        end
    end

    logic [NBANK*NCH-1:0] flag_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam int IDX = b*NCH + c;
            localparam int POS = b*BANK_STRIDE + c;
            // event has priority over a clear in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flag_q[IDX] <= 1'b0;
                else if (ev_all[IDX])
                    flag_q[IDX] <= 1'b1;
                else if (clr[POS])
                    flag_q[IDX] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_irq_abort_fsm.sv
module dma_irq_abort_fsm
    import dma_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic flag_ev,
    output logic req
);

    ab_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= AB_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AB_IDLE: if (req_set) state_d = AB_PEND;
            AB_PEND: if (flag_ev) state_d = AB_ACK;
            AB_ACK:  state_d = req_set ? AB_PEND : AB_IDLE;
            default: state_d = AB_IDLE;
        endcase
    end

    always_comb begin
        req = (state_q != AB_IDLE);
    end

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [1:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    input  logic [NCH-1:0] ev_err,
    input  logic [NCH-1:0] ev_abt,
    input  logic [NCH-1:0] ev_tc,
    input  logic [NCH-1:0] ch_busy,
    output logic [NCH-1:0] abort_req,
    output logic           irq,
    output logic           idle
);

    localparam logic [DW-1:0] IMPL = impl_bits(NCH);

    logic          wr_stat, wr_mask, wr_abt;
    logic [DW-1:0] clr, stat_q, mask_q;
    logic [NCH-1:0] ongoing;

    assign wr_stat = bus_sel && bus_we && (bus_addr == RG_STATUS);
    assign wr_mask = bus_sel && bus_we && (bus_addr == RG_MASK);
    assign wr_abt  = bus_sel && bus_we && (bus_addr == RG_ABORT);
    assign clr     = wr_stat ? bus_wdata : '0;

    dma_irq_flags #(.NCH(NCH)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_err (ev_err),
        .ev_abt (ev_abt),
        .ev_tc  (ev_tc),
        .clr    (clr),
        .stat   (stat_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_abort
        dma_irq_abort_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_set (wr_abt && bus_wdata[c]),
            .flag_ev (ev_abt[c]),
            .req     (abort_req[c])
        );
        assign ongoing[c] = ~(stat_q[c] | stat_q[BANK_STRIDE + c] | stat_q[2*BANK_STRIDE + c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= IMPL;
        else if (wr_mask)
            mask_q <= bus_wdata & IMPL;
    end

    assign irq  = |(stat_q & ~mask_q);
    assign idle = ~|ch_busy;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RG_STATUS: bus_rdata = stat_q;
            RG_MASK:   bus_rdata = mask_q;
            RG_ABORT:  bus_rdata[NCH-1:0] = abort_req;
            RG_IDLE: begin
                bus_rdata[0] = idle;
                bus_rdata[BANK_STRIDE +: NCH] = ongoing;
            end
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_sel,
    input logic           bus_we,
    input logic [1:0]     bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [NCH-1:0] ev_err,
    input logic [NCH-1:0] ev_abt,
    input logic [NCH-1:0] ev_tc,
    input logic [DW-1:0]  stat_q,
    input logic [DW-1:0]  mask_q,
    input logic [NCH-1:0] abort_req,
    input logic           irq
);

    logic wst, wmk, wab;
    assign wst = bus_sel && bus_we && (bus_addr == RG_STATUS);
    assign wmk = bus_sel && bus_we && (bus_addr == RG_MASK);
    assign wab = bus_sel && bus_we && (bus_addr == RG_ABORT);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_err[c] |=> stat_q[c]); // R1
        AST_ABT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_abt[c] |=> stat_q[BANK_STRIDE + c]); // R1
        AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            ev_tc[c] |=> stat_q[2*BANK_STRIDE + c]); // R3
        AST_TC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wst && bus_wdata[2*BANK_STRIDE + c] && !ev_tc[c]) |=> !stat_q[2*BANK_STRIDE + c]); // R2
        AST_UNMASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_tc[c] && !mask_q[2*BANK_STRIDE + c] && !wmk) |=> irq); // R5
        AST_ABORT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            (wab && bus_wdata[c]) |=> abort_req[c]); // R6
        AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (abort_req[c] && ev_abt[c] && !(wab && bus_wdata[c])) ##1 !(wab && bus_wdata[c])
            |=> !abort_req[c]); // R7
    end

endmodule

bind dma_irq_unit dma_irq_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ev_err    (ev_err),
    .ev_abt    (ev_abt),
    .ev_tc     (ev_tc),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .abort_req (abort_req),
    .irq       (irq)
);

// File: tb/sim_dma_irq_unit.sv
module sim_dma_irq_unit;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]     bus_addr = 2'd0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] ev_err = '0, ev_abt = '0, ev_tc = '0, ch_busy = '0;
    logic [NCH-1:0] abort_req;
    logic           irq, idle;

    always #10 clk = ~clk;

    dma_irq_unit #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_err(ev_err), .ev_abt(ev_abt), .ev_tc(ev_tc), .ch_busy(ch_busy),
        .abort_req(abort_req), .irq(irq), .idle(idle)
    );

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 abort_req, 3 idle
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0, n_err = 0;
    bit    done = 0;

    task automatic expect_val(input int kind, input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        #1;
        it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_wdata = '0;
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = bus_rdata;
                    1: act = {31'd0, irq};
                    2: act = {{(32-NCH){1'b0}}, abort_req};
                    default: act = {31'd0, idle};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state, R4 reset mask, R8 idle, R9 all ongoing
        expect_val(0, 2'd0, 32'h0, "R10 status after reset");
        expect_val(2, 2'd0, 32'h0, "R10 abort_req after reset");
        expect_val(1, 2'd0, 32'h0, "R10 irq after reset");
        expect_val(0, 2'd1, 32'h00FF_FFFF, "R4 mask reset value");
        expect_val(3, 2'd0, 32'h1, "R8 idle port");
        expect_val(0, 2'd3, 32'h0000_FF01, "R9 idle/ongoing word");

        // R1 events in each bank
        ev_err[2] = 1; ev_abt[5] = 1; ev_tc[7] = 1;
        @(negedge clk);
        ev_err = '0; ev_abt = '0; ev_tc = '0;
        expect_val(0, 2'd0, 32'h0080_2004, "R1 bank positions");
        expect_val(1, 2'd0, 32'h0, "R4 masked events keep irq low");

        // R4/R5 unmask terminal count of channel 7
        wr(2'd1, 32'h007F_FFFF);
        expect_val(0, 2'd1, 32'h007F_FFFF, "R4 mask readback");
        expect_val(1, 2'd0, 32'h1, "R5 unmasked flag raises irq");

        // R2 write-one-to-clear, zeros ignored
        wr(2'd0, 32'h0080_0000);
        expect_val(0, 2'd0, 32'h0000_2004, "R2 clear one bit");
        expect_val(1, 2'd0, 32'h0, "R5 irq drops after clear");
        wr(2'd0, 32'h0);
        expect_val(0, 2'd0, 32'h0000_2004, "R2 zero write no effect");

        // R3 event and clear on bit 17 in the same cycle; bit 2 cleared alone
        ev_tc[1] = 1;
        bus_sel = 1; bus_we = 1; bus_addr = 2'd0; bus_wdata = 32'h0002_0004;
        @(negedge clk);
        ev_tc = '0; bus_sel = 0; bus_we = 0; bus_wdata = '0;
        expect_val(0, 2'd0, 32'h0002_2000, "R3 event beats clear");

        // R9 ongoing view, R8 busy
        expect_val(0, 2'd3, 32'h0000_DD01, "R9 ongoing channels");
        ch_busy[3] = 1;
        expect_val(3, 2'd0, 32'h0, "R8 idle low when busy");
        expect_val(0, 2'd3, 32'h0000_DD00, "R8 idle bit in word");
        ch_busy = '0;

        // R6 abort requests
        wr(2'd2, 32'h0000_0009);
        expect_val(2, 2'd0, 32'h9, "R6 abort_req raised");
        expect_val(0, 2'd2, 32'h9, "R6 abort readback");
        wr(2'd2, 32'h0);
        expect_val(2, 2'd0, 32'h9, "R6 zero write no effect");

        // R7 abort event on channel 0: request drops one cycle after flag
        ev_abt[0] = 1;
        @(negedge clk);
        ev_abt = '0;
        expect_val(2, 2'd0, 32'h9, "R7 request held while flag set");
        expect_val(2, 2'd0, 32'h8, "R7 request dropped");
        expect_val(0, 2'd0, 32'h0002_2100, "R1 abort flag set");

        // R11 upper bits ignored
        wr(2'd1, 32'hFF00_0000);
        expect_val(0, 2'd1, 32'h0, "R11 upper mask bits ignored");
        expect_val(1, 2'd0, 32'h1, "R5 all unmasked irq");
        wr(2'd0, 32'hFFFF_FFFF);
        expect_val(0, 2'd0, 32'h0, "R11 status clear all");
        expect_val(1, 2'd0, 32'h0, "R2 irq low after full clear");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule